// File: doc/BRIEF.md
# Multiplexed 64-bit data phase handler

This block extends a 32-bit local-bus target so it can take part in 64-bit transfers. In such a transfer the 30 address pins and the D/C and M/IO cycle-type pins are reused in the data phase to carry the upper 32 data bits. The lower 32 bits stay on the normal data bus. The base target controller decodes the address and raises a claim for the cycle. This block watches the master's active-low 64-bit size request at the address strobe. When the request is present, the cycle is claimed and the device is configured wide, it drives the active-low 64-bit acknowledge.

In the data phase of a write, the block assembles the 64-bit word from the reused pins and the data bus, maps the eight active-low byte enables to an active-high mask, and hands both to the back end on the clock after ready. In a read, the block drives the back end's 64-bit word onto the data bus and the reused pins under output-enable signals. The data-bus enable is high in every data-phase cycle of a claimed read. The reused-pin enable is high only in the data-phase cycles of a wide read. Both drop on the clock after ready. In a 32-bit cycle the reused pins are never treated as data.

Top module: `mux64_data_phase`

## Requirements
- R1: While reset is asserted, and right after it is released, ack64_no is high and apin_oe_o, data_oe_o, xfer_o and wr_valid_o are low.
- R2: ack64_no goes low in an address-phase cycle (ads_ni low, block idle) when claim_i is high, req64_ni is low and cfg_wide_i is high. It stays low through every data-phase cycle and goes high on the clock after the edge that samples lrdy_ni low.
- R3: ack64_no stays high when, at the address phase, req64_ni is high, cfg_wide_i is low or claim_i is low.
- R4: For a wide write, the edge that samples lrdy_ni low captures a word whose bits [63:34] are apin_i[29:0], bit 33 is dc_i, bit 32 is mio_i and bits [31:0] are data_i. wr_data_o presents this word, and wr_valid_o is high for exactly the one following cycle.
- R5: For a 32-bit write, bits [63:32] of wr_data_o are zero and bits [7:4] of wr_be_o are zero, whatever the reused pins and be_ni[7:4] carry.
- R6: Byte enables are active low. be_ni bit k low sets mask bit k, which covers data bits [8k+7:8k]. be_o shows the mask during the data phase, and wr_be_o holds the captured mask of a write.
- R7: In a claimed read, data_oe_o is high in every data-phase cycle. apin_oe_o is high in those cycles only when the read is wide. Both are low in address-phase and idle cycles, and both drop on the clock after ready.
- R8: While the reused pins are driven in a read, apin_o carries rd_data_i[63:34], dc_o carries bit 33, mio_o carries bit 32, and data_o carries rd_data_i[31:0].
- R9: A cycle whose address phase sees claim_i low is ignored: no acknowledge, no output enable, no xfer_o and no wr_valid_o.
- R10: The data phase lasts until lrdy_ni is sampled low. An ads_ni pulse during the data phase starts no new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wide_i | input | 1 | Device allows 64-bit transfers |
| ads_ni | input | 1 | Address strobe, active low |
| claim_i | input | 1 | Base controller claims this cycle |
| req64_ni | input | 1 | Master 64-bit size request, active low |
| wr_i | input | 1 | Write (1) or read (0), sampled at address phase |
| lrdy_ni | input | 1 | Local ready ending the data phase, active low |
| ack64_no | output | 1 | 64-bit acknowledge, active low |
| apin_i | input | 30 | Address pins 31:2 / upper data 63:34 |
| dc_i | input | 1 | D/C pin / data bit 33 |
| mio_i | input | 1 | M/IO pin / data bit 32 |
| apin_o | output | 30 | Read data bits 63:34 for the address pins |
| dc_o | output | 1 | Read data bit 33 |
| mio_o | output | 1 | Read data bit 32 |
| apin_oe_o | output | 1 | Drive enable for the reused pins |
| data_i | input | 32 | Data bus, bits 31:0 |
| data_o | output | 32 | Read data bits 31:0 |
| data_oe_o | output | 1 | Drive enable for the data bus |
| be_ni | input | 8 | Byte enables, active low |
| xfer_o | output | 1 | Claimed data phase in progress |
| xfer_wr_o | output | 1 | Current transfer is a write |
| xfer_wide_o | output | 1 | Current transfer is 64-bit |
| be_o | output | 8 | Active-high byte mask in the data phase |
| rd_data_i | input | 64 | Back-end read word |
| wr_valid_o | output | 1 | One-cycle pulse with captured write word |
| wr_data_o | output | 64 | Captured write word |
| wr_be_o | output | 8 | Captured write byte mask |

## Verification
On every cycle the assertions check the following. The acknowledge stays off whenever the request, the claim or the wide setting is missing. Once given, it holds until ready. The reused-pin enable is never high without the data-bus enable. Both enables fall after a ready edge. Each write handoff is a single-cycle pulse with zero upper bits in a 32-bit cycle. Only the bench scenarios can show that the bit placement of the assembled and driven 64-bit words is correct, along with the byte-mask mapping, the handling of wait states, the ignoring of strobes during the data phase, and the ignoring of unclaimed cycles.

// File: rtl/mux64_pkg.sv
package mux64_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/mux64_phase_fsm.sv
module mux64_phase_fsm
  import mux64_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_wide_i,
  input  logic ads_ni,
  input  logic claim_i,
  input  logic req64_ni,
  input  logic wr_i,
  input  logic lrdy_ni,
  output logic in_data_o,
  output logic wide_o,
  output logic wr_o,
  output logic done_o,
  output logic ack64_no
);
  phase_e ph_q;
  logic   wide_q, wr_q;
  logic   start, wide_req;

  assign start    = (ph_q == PH_IDLE) && !ads_ni && claim_i;
  assign wide_req = start && !req64_ni && cfg_wide_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      wide_q <= 1'b0;
      wr_q   <= 1'b0;
    end else if (start) begin
      ph_q   <= PH_DATA;
      wide_q <= wide_req;
      wr_q   <= wr_i;
    end else if (ph_q == PH_DATA && !lrdy_ni) begin
      ph_q   <= PH_IDLE;
      wide_q <= 1'b0;
    end
  end

  assign in_data_o = (ph_q == PH_DATA);
  assign wide_o    = wide_q;
  assign wr_o      = wr_q;
  assign done_o    = in_data_o && !lrdy_ni;
  // acknowledge from the address phase through the data phase
  assign ack64_no  = !(wide_req || wide_q);

  a_r3_no_ack_unqualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_IDLE && (req64_ni || !cfg_wide_i || !claim_i)) |-> ack64_no);

  a_r2_ack_held_to_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack64_no && ph_q == PH_DATA && lrdy_ni) |=> !ack64_no);

  a_r10_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_DATA && lrdy_ni) |=> (ph_q == PH_DATA && $stable(wr_q)));
endmodule

// File: rtl/mux64_be_map.sv
module mux64_be_map #(
  parameter int BE_W  = 8,
  parameter int LO_BE = 4
) (
  input  logic [BE_W-1:0] be_ni,
  input  logic            wide_i,
  output logic [BE_W-1:0] be_o
);
  for (genvar k = 0; k < BE_W; k++) begin : g_lane
    if (k < LO_BE) begin : g_lo
      assign be_o[k] = !be_ni[k];
    end else begin : g_hi
      assign be_o[k] = !be_ni[k] && wide_i;
    end
  end
endmodule

// File: rtl/mux64_lanes.sv
module mux64_lanes #(
  parameter int ADDR_W = 30,
  parameter int LO_W   = 32,
  localparam int WIDE_W = LO_W + ADDR_W + 2,
  localparam int BE_W   = WIDE_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_data_i,
  input  logic              wide_i,
  input  logic              wr_i,
  input  logic              done_i,
  input  logic [ADDR_W-1:0] apin_i,
  input  logic              dc_i,
  input  logic              mio_i,
  input  logic [LO_W-1:0]   data_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [WIDE_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] apin_o,
  output logic              dc_o,
  output logic              mio_o,
  output logic [LO_W-1:0]   data_o,
  output logic              apin_oe_o,
  output logic              data_oe_o,
  output logic              wr_valid_o,
  output logic [WIDE_W-1:0] wr_data_o,
  output logic [BE_W-1:0]   wr_be_o
);
  logic [ADDR_W+1:0] hi_in;
  logic              wide_cap_q;

  // reused pins are data only in a wide cycle
  assign hi_in = wide_i ? {apin_i, dc_i, mio_i} : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o <= 1'b0;
      wr_data_o  <= '0;
      wr_be_o    <= '0;
      wide_cap_q <= 1'b0;
    end else begin
      wr_valid_o <= done_i && wr_i;
      if (done_i && wr_i) begin
        wr_data_o  <= {hi_in, data_i};
        wr_be_o    <= be_i;
        wide_cap_q <= wide_i;
      end
    end
  end

  assign data_oe_o = in_data_i && !wr_i;
  assign apin_oe_o = in_data_i && !wr_i && wide_i;
  assign data_o    = rd_data_i[LO_W-1:0];
  assign mio_o     = rd_data_i[LO_W];
  assign dc_o      = rd_data_i[LO_W+1];
  assign apin_o    = rd_data_i[WIDE_W-1 -: ADDR_W];

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  a_r5_narrow_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wide_cap_q) |-> (wr_data_o[WIDE_W-1:LO_W] == '0));

  a_r7_release_after_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !wr_i) |=> (!data_oe_o && !apin_oe_o));
endmodule

// File: rtl/mux64_data_phase.sv
module mux64_data_phase #(
  parameter int ADDR_W = 30,
  parameter int LO_W   = 32,
  localparam int WIDE_W = LO_W + ADDR_W + 2,
  localparam int BE_W   = WIDE_W / 8,
  localparam int LO_BE  = LO_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wide_i,
  input  logic              ads_ni,
  input  logic              claim_i,
  input  logic              req64_ni,
  input  logic              wr_i,
  input  logic              lrdy_ni,
  output logic              ack64_no,
  input  logic [ADDR_W-1:0] apin_i,
  input  logic              dc_i,
  input  logic              mio_i,
  output logic [ADDR_W-1:0] apin_o,
  output logic              dc_o,
  output logic              mio_o,
  output logic              apin_oe_o,
  input  logic [LO_W-1:0]   data_i,
  output logic [LO_W-1:0]   data_o,
  output logic              data_oe_o,
  input  logic [BE_W-1:0]   be_ni,
  output logic              xfer_o,
  output logic              xfer_wr_o,
  output logic              xfer_wide_o,
  output logic [BE_W-1:0]   be_o,
  input  logic [WIDE_W-1:0] rd_data_i,
  output logic              wr_valid_o,
  output logic [WIDE_W-1:0] wr_data_o,
  output logic [BE_W-1:0]   wr_be_o
);
  logic in_data, wide, wr, done;
  logic [BE_W-1:0] be_map;

  mux64_phase_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_wide_i (cfg_wide_i),
    .ads_ni     (ads_ni),
    .claim_i    (claim_i),
    .req64_ni   (req64_ni),
    .wr_i       (wr_i),
    .lrdy_ni    (lrdy_ni),
    .in_data_o  (in_data),
    .wide_o     (wide),
    .wr_o       (wr),
    .done_o     (done),
    .ack64_no   (ack64_no)
  );

  mux64_be_map #(.BE_W(BE_W), .LO_BE(LO_BE)) i_be_map (
    .be_ni  (be_ni),
    .wide_i (wide),
    .be_o   (be_map)
  );

  mux64_lanes #(.ADDR_W(ADDR_W), .LO_W(LO_W)) i_lanes (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_data_i  (in_data),
    .wide_i     (wide),
    .wr_i       (wr),
    .done_i     (done),
    .apin_i     (apin_i),
    .dc_i       (dc_i),
    .mio_i      (mio_i),
    .data_i     (data_i),
    .be_i       (be_map),
    .rd_data_i  (rd_data_i),
    .apin_o     (apin_o),
    .dc_o       (dc_o),
    .mio_o      (mio_o),
    .data_o     (data_o),
    .apin_oe_o  (apin_oe_o),
    .data_oe_o  (data_oe_o),
    .wr_valid_o (wr_valid_o),
    .wr_data_o  (wr_data_o),
    .wr_be_o    (wr_be_o)
  );

  assign xfer_o      = in_data;
  assign xfer_wr_o   = in_data && wr;
  assign xfer_wide_o = in_data && wide;
  assign be_o        = in_data ? be_map : '0;

  a_r7_pins_need_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apin_oe_o |-> data_oe_o);

  a_r2_ack_implies_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack64_no && xfer_o) |-> xfer_wide_o);
endmodule

// File: tb/test_mux64_data_phase.sv
module test_mux64_data_phase;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wide_i = 1'b1, ads_ni = 1'b1, claim_i = 1'b0, req64_ni = 1'b1;
  logic        wr_i = 1'b0, lrdy_ni = 1'b1;
  logic        ack64_no;
  logic [29:0] apin_i = '0, apin_o;
  logic        dc_i = 1'b0, mio_i = 1'b0, dc_o, mio_o, apin_oe_o;
  logic [31:0] data_i = '0, data_o;
  logic        data_oe_o;
  logic [7:0]  be_ni = 8'hff, be_o, wr_be_o;
  logic        xfer_o, xfer_wr_o, xfer_wide_o, wr_valid_o;
  logic [63:0] rd_data_i = '0, wr_data_o;

  int total = 0;
  int bad = 0;

  typedef struct packed {
    logic [63:0] d;
    logic [7:0]  be;
  } item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;

  mux64_data_phase i_mux64_data_phase (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_wide_i(cfg_wide_i), .ads_ni(ads_ni),
    .claim_i(claim_i), .req64_ni(req64_ni), .wr_i(wr_i), .lrdy_ni(lrdy_ni),
    .ack64_no(ack64_no), .apin_i(apin_i), .dc_i(dc_i), .mio_i(mio_i),
    .apin_o(apin_o), .dc_o(dc_o), .mio_o(mio_o), .apin_oe_o(apin_oe_o),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o), .be_ni(be_ni),
    .xfer_o(xfer_o), .xfer_wr_o(xfer_wr_o), .xfer_wide_o(xfer_wide_o), .be_o(be_o),
    .rd_data_i(rd_data_i), .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o),
    .wr_be_o(wr_be_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one bus cycle: address phase, data phase with waits, recovery cycle
  task automatic bus_cycle(input bit claim, input bit req64, input bit cfg, input bit wr,
                           input logic [29:0] addr, input logic [63:0] wdata,
                           input logic [7:0] ben, input int waits, input logic [63:0] rdata);
    bit wide;
    logic [7:0] mask;
    wide = claim && req64 && cfg;
    mask = wide ? ~ben : {4'h0, ~ben[3:0]};
    @(negedge clk);
    cfg_wide_i = cfg; ads_ni = 1'b0; claim_i = claim; req64_ni = !req64; wr_i = wr;
    apin_i = addr; dc_i = 1'b1; mio_i = 1'b1; rd_data_i = rdata;
    #1;
    chk("R2 R3 ack in address phase", 64'(ack64_no), 64'(!wide));
    chk("R7 no enable in address phase", {62'b0, apin_oe_o, data_oe_o}, 64'd0);
    @(negedge clk);
    ads_ni = 1'b1;
    apin_i = wdata[63:34]; dc_i = wdata[33]; mio_i = wdata[32]; data_i = wdata[31:0];
    be_ni = ben; lrdy_ni = (waits > 0);
    for (int w = 0; w <= waits; w++) begin
      if (w > 0) begin
        @(negedge clk);
        lrdy_ni = (w < waits);
        ads_ni = (w == 1) ? 1'b0 : 1'b1;  // R10 stray strobe in data phase
      end
      #1;
      chk("R2 R3 R9 ack in data phase", 64'(ack64_no), 64'(!wide));
      chk("R9 R10 xfer in data phase", 64'(xfer_o), 64'(claim));
      chk("R7 R9 data_oe", 64'(data_oe_o), 64'(claim && !wr));
      chk("R7 apin_oe", 64'(apin_oe_o), 64'(wide && !wr));
      if (claim) chk("R6 be_o mask", 64'(be_o), 64'(mask));
      if (claim && !wr) begin
        chk("R8 low data drive", 64'(data_o), 64'(rdata[31:0]));
        if (wide) chk("R8 reused pin drive", {32'b0, apin_o, dc_o, mio_o}, {32'b0, rdata[63:32]});
      end
    end
    if (claim && wr) exp_q.push_back('{d: wide ? wdata : {32'b0, wdata[31:0]}, be: mask});
    @(negedge clk);
    ads_ni = 1'b1; lrdy_ni = 1'b1; claim_i = 1'b0; req64_ni = 1'b1;
    #1;
    chk("R2 ack released after ready", 64'(ack64_no), 64'd1);
    chk("R7 enables released after ready", {62'b0, apin_oe_o, data_oe_o}, 64'd0);
    chk("R10 cycle ended after ready", 64'(xfer_o), 64'd0);
  endtask

  // scoreboard monitor
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (rst_ni && wr_valid_o) begin
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R9 unexpected wr_valid_o act=%h exp=none", wr_data_o);
        end else begin
          it = exp_q.pop_front();
          chk("R4 R5 write word", wr_data_o, it.d);
          chk("R5 R6 write mask", 64'(wr_be_o), 64'(it.be));
          @(negedge clk);
          chk("R4 single-cycle valid", 64'(wr_valid_o), 64'd0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {59'b0, ack64_no, apin_oe_o, data_oe_o, xfer_o, wr_valid_o},
        {59'b0, 1'b1, 4'b0});
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release", {59'b0, ack64_no, apin_oe_o, data_oe_o, xfer_o, wr_valid_o},
        {59'b0, 1'b1, 4'b0});
    // wide write, no wait
    bus_cycle(1, 1, 1, 1, 30'h0abc_1234, 64'hDEAD_BEEF_0123_4567, 8'h00, 0, '0);
    // wide write, waits, partial enables (R10, R6)
    bus_cycle(1, 1, 1, 1, 30'h1111_2222, 64'h8000_0003_F00D_CAFE, 8'hA5, 3, '0);
    // 32-bit write: no request (R5, R3)
    bus_cycle(1, 0, 1, 1, 30'h0000_0040, 64'hFFFF_FFFF_1234_5678, 8'h0F, 1, '0);
    // 32-bit write: device configured narrow (R3)
    bus_cycle(1, 1, 0, 1, 30'h0000_0080, 64'hAAAA_5555_9ABC_DEF0, 8'h30, 0, '0);
    // wide read (R8)
    bus_cycle(1, 1, 1, 0, 30'h0000_0100, '0, 8'h00, 2, 64'hC000_0001_5A5A_A5A5);
    // narrow read (R7)
    bus_cycle(1, 0, 1, 0, 30'h0000_0200, '0, 8'hF0, 0, 64'h7777_8888_1357_2468);
    // unclaimed cycle (R9)
    bus_cycle(0, 1, 1, 1, 30'h0000_0300, 64'h1234_5678_9ABC_DEF0, 8'h00, 0, '0);
    bus_cycle(0, 1, 1, 0, 30'h0000_0304, '0, 8'h00, 0, 64'h1);
    repeat (4) @(negedge clk);
    chk("R9 scoreboard drained", 64'(exp_q.size()), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule